// File: doc/BRIEF.md
# ADC Result Threshold Event Counter

This block sits behind an ADC and inspects every 16-bit conversion result as it arrives with its valid strobe. Each result is reduced to a magnitude, either taken as an unsigned number or, in two's-complement format, as its absolute value. The magnitude is then compared with a programmable threshold. A one-cycle trip pulse marks every result whose magnitude is strictly above the threshold.

An 8-bit event counter follows the run of results at or above the threshold. Every such result adds one to the counter. A result below the threshold either takes one off the counter or clears it, depending on the selected mode. The counter is compared with a programmable limit. Reaching the limit produces a one-cycle interrupt pulse and sets a sticky status flag, which software clears through a clear strobe.

Top module: `adc_thr_event_counter`

## Requirements
- R1: After a synchronous reset, `event_count` is 0x00 and `trip_pulse`, `limit_irq` and `limit_flag` are all low.
- R2: When `cfg_signed` is 0, the magnitude is the raw unsigned result. When `cfg_signed` is 1, the magnitude is the absolute value of the two's-complement result, with 0x8000 clamped to 0x7FFF, and bit 15 of `thr_value` is ignored.
- R3: In the counting modes (`cfg_mode` 2'b10 or 2'b11), a valid result whose magnitude is at least the threshold increments `event_count` by one, one cycle after the strobe. The counter saturates at 0xFF.
- R4: In mode 2'b10, a valid result whose magnitude is below the threshold decrements `event_count`. The counter saturates at 0x00.
- R5: In mode 2'b11, a valid result whose magnitude is below the threshold clears `event_count` to 0x00.
- R6: In a counting mode, a cycle without `res_valid` leaves `event_count` unchanged.
- R7: `trip_pulse` is high for exactly the one cycle after a valid result whose magnitude is strictly greater than the threshold, in any mode other than 2'b00.
- R8: In mode 2'b00 (off) and mode 2'b01 (compare only), `event_count` is 0x00 one cycle later and stays there. In mode 2'b00, `trip_pulse` and `limit_irq` never assert.
- R9: In a counting mode, `limit_irq` is a one-cycle pulse in the first cycle in which `event_count` equals `cnt_limit`.
- R10: `limit_flag` is set in the cycle after a counter/limit match and stays set until `status_clear` is sampled high with no match. If a match and a clear fall in the same cycle, the match wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Strobe marking a conversion result |
| res_data | input | 16 | Conversion result |
| cfg_signed | input | 1 | 1 = two's-complement results, 0 = unsigned |
| cfg_mode | input | 2 | 00 off, 01 compare only, 10 count with decrement, 11 count with clear |
| thr_value | input | 16 | Magnitude threshold |
| cnt_limit | input | 8 | Counter value that raises the limit interrupt |
| status_clear | input | 1 | Clears the sticky limit flag |
| event_count | output | 8 | Threshold event counter |
| trip_pulse | output | 1 | One-cycle comparator trip |
| limit_irq | output | 1 | One-cycle pulse when the counter reaches the limit |
| limit_flag | output | 1 | Sticky limit-reached status |

## Verification
The hardest states to reach from the ports are the two saturation points, because each needs hundreds of consecutive results of one kind. The bench therefore streams 300 above-threshold results to pin the counter at 0xFF, and then 300 below-threshold results in decrement mode to hold it at zero. The clamped magnitude of 0x8000 is probed with a threshold of 0x7FFF. At that threshold the result must count as a hit but must not trip. A behavioural model is compared with the outputs on every cycle.

// File: rtl/thr_pkg.sv
package thr_pkg;

    parameter int unsigned RES_W = 16;
    parameter int unsigned CNT_W = 8;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_CMP     = 2'b01,
        MODE_CNT_DEC = 2'b10,
        MODE_CNT_CLR = 2'b11
    } thr_mode_e;

    typedef struct packed {
        logic valid;   // strobe qualified by an enabled mode
        logic hit;     // magnitude >= threshold
        logic trip;    // magnitude >  threshold
    } cmp_ev_t;

    function automatic logic mode_counts(thr_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/thr_compare.sv
module thr_compare
    import thr_pkg::*;
#(
    parameter int unsigned DW = RES_W
) (
    input  logic          valid,
    input  logic [DW-1:0] data,
    input  logic          sgn,
    input  logic [DW-1:0] thr,
    input  thr_mode_e     mode,
    output cmp_ev_t       ev
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] mag;
    logic [DW-1:0] thr_eff;

    always_comb begin
        if (sgn && data[DW-1]) begin
            if (data == MOST_NEG) mag = MOST_POS;
            else                  mag = ~data + 1'b1;
        end else begin
            mag = data;
        end
        thr_eff  = sgn ? {1'b0, thr[DW-2:0]} : thr;
        ev.valid = valid && (mode != MODE_OFF);
        ev.hit   = (mag >= thr_eff);
        ev.trip  = ev.valid && (mag > thr_eff);
    end

    always_comb begin
        assert_mag_range_R2: assert (!sgn || !mag[DW-1]);
    end
endmodule

// File: rtl/thr_counter.sv
module thr_counter
    import thr_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  thr_mode_e     mode,
    input  cmp_ev_t       ev,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_next;

    always_comb begin
        cnt_next = cnt;
        if (!mode_counts(mode)) begin
            cnt_next = '0;
        end else if (ev.valid) begin
            if (ev.hit) begin
                if (cnt != CNT_MAX) cnt_next = cnt + 1'b1;
            end else if (mode == MODE_CNT_CLR) begin
                cnt_next = '0;
            end else if (cnt != '0) begin
                cnt_next = cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_next;
    end

    assert_sat_high_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_counts(mode) && ev.valid && ev.hit && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CNT_DEC && ev.valid && !ev.hit && cnt == '0) |=> (cnt == '0));
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CNT_CLR && ev.valid && !ev.hit) |=> (cnt == '0));
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_counts(mode) && !ev.valid) |=> (cnt == $past(cnt)));
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!mode_counts(mode)) |=> (cnt == '0));
endmodule

// File: rtl/thr_limit.sv
module thr_limit
    import thr_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  thr_mode_e     mode,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] limit,
    input  logic          clr,
    output logic          irq,
    output logic          flag
);
    logic match;
    logic match_d;

    assign match = mode_counts(mode) && (cnt == limit);
    assign irq   = match && !match_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_d <= 1'b0;
            flag    <= 1'b0;
        end else begin
            match_d <= match;
            flag    <= match || (flag && !clr);
        end
    end

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
        irq |=> flag);
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/adc_thr_event_counter.sv
module adc_thr_event_counter
    import thr_pkg::*;
#(
    parameter int unsigned DW = RES_W,
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          cfg_signed,
    input  logic [1:0]    cfg_mode,
    input  logic [DW-1:0] thr_value,
    input  logic [CW-1:0] cnt_limit,
    input  logic          status_clear,
    output logic [CW-1:0] event_count,
    output logic          trip_pulse,
    output logic          limit_irq,
    output logic          limit_flag
);
    thr_mode_e mode;
    cmp_ev_t   ev;

    assign mode = thr_mode_e'(cfg_mode);

    thr_compare #(.DW(DW)) u_cmp (
        .valid (res_valid),
        .data  (res_data),
        .sgn   (cfg_signed),
        .thr   (thr_value),
        .mode  (mode),
        .ev    (ev)
    );

    thr_counter #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .ev   (ev),
        .cnt  (event_count)
    );

    thr_limit #(.CW(CW)) u_lim (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .cnt   (event_count),
        .limit (cnt_limit),
        .clr   (status_clear),
        .irq   (limit_irq),
        .flag  (limit_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) trip_pulse <= 1'b0;
        else     trip_pulse <= ev.trip;
    end

    assert_trip_source_R7: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> $past(res_valid && cfg_mode != 2'b00));
    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00) |-> !limit_irq);
endmodule

// File: tb/tb_adc_thr_event_counter.sv
`timescale 1ns/1ps
module tb_adc_thr_event_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        cfg_signed = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [15:0] thr_value = '0;
    logic [7:0]  cnt_limit = '0;
    logic        status_clear = 1'b0;
    logic [7:0]  event_count;
    logic        trip_pulse, limit_irq, limit_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_thr_event_counter dut (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .cfg_signed(cfg_signed), .cfg_mode(cfg_mode), .thr_value(thr_value),
        .cnt_limit(cnt_limit), .status_clear(status_clear),
        .event_count(event_count), .trip_pulse(trip_pulse),
        .limit_irq(limit_irq), .limit_flag(limit_flag)
    );

    // ---------------- behavioural reference ----------------
    int m_cnt = 0;
    bit m_trip = 0, m_flag = 0, m_match_d = 0;

    function automatic int ref_mag(logic [15:0] d, logic s);
        int v;
        if (!s) return int'(d);
        v = int'($signed(d));
        if (v < 0) v = -v;
        if (v > 32767) v = 32767;
        return v;
    endfunction

    function automatic int ref_thr(logic [15:0] t, logic s);
        return s ? int'(t) % 32768 : int'(t);
    endfunction

    function automatic bit ref_match();
        return (cfg_mode >= 2) && (m_cnt == int'(cnt_limit));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_trip = 0; m_flag = 0; m_match_d = 0;
        end else begin
            int mg, th;
            bit mt;
            mt = ref_match();
            m_flag = mt || (m_flag && !status_clear);
            m_match_d = mt;
            mg = ref_mag(res_data, cfg_signed);
            th = ref_thr(thr_value, cfg_signed);
            m_trip = res_valid && cfg_mode != 0 && mg > th;
            if (cfg_mode < 2) m_cnt = 0;
            else if (res_valid) begin
                if (mg >= th) m_cnt = (m_cnt < 255) ? m_cnt + 1 : 255;
                else if (cfg_mode == 3) m_cnt = 0;
                else m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 R4 R5 R6 R8 count", event_count, m_cnt);
            chk("R7 trip", trip_pulse, m_trip);
            chk("R9 limit_irq", limit_irq, ref_match() && !m_match_d);
            chk("R10 limit_flag", limit_flag, m_flag);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(bit v, logic [15:0] d);
        @(posedge clk); #1;
        res_valid = v; res_data = d;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 reset count", event_count, 0);
        chk("R1 reset trip", trip_pulse, 0);
        chk("R1 reset irq", limit_irq, 0);
        chk("R1 reset flag", limit_flag, 0);

        // compare only: trips, but the counter stays at zero
        cnt_limit = 8'd3; thr_value = 16'd100; cfg_mode = 2'b01;
        step(1, 16'd150); step(0, 0);
        chk("R7 trip above", trip_pulse, 1);
        chk("R8 cmp-only count", event_count, 0);
        step(1, 16'd100); step(0, 0);
        chk("R7 equal no trip", trip_pulse, 0);

        // count / decrement
        cfg_mode = 2'b10;
        step(1, 16'd200); step(1, 16'd100); step(1, 16'd300); step(0, 0);
        chk("R3 three hits", event_count, 3);
        chk("R9 irq at limit", limit_irq, 1);
        step(0, 0);
        chk("R9 irq single", limit_irq, 0);
        chk("R10 flag set", limit_flag, 1);
        step(1, 16'd5); step(0, 0);
        chk("R4 decrement", event_count, 2);
        repeat (4) step(0, 0);
        chk("R6 hold", event_count, 2);
        chk("R10 flag sticky", limit_flag, 1);
        status_clear = 1; step(0, 0); status_clear = 0; step(0, 0);
        chk("R10 flag cleared", limit_flag, 0);

        // count / clear
        cfg_mode = 2'b11;
        step(1, 16'd500); step(1, 16'd7); step(0, 0);
        chk("R5 clear on miss", event_count, 0);

        // signed magnitudes
        cfg_mode = 2'b10; cfg_signed = 1; thr_value = 16'h8064;
        step(1, 16'hFF6A); step(0, 0);
        chk("R2 negative hit", event_count, 1);
        chk("R2 negative trip", trip_pulse, 1);
        step(1, 16'hFFCE); step(0, 0);
        chk("R2 small negative miss", event_count, 0);
        thr_value = 16'h7FFF;
        step(1, 16'h8000); step(0, 0);
        chk("R2 most negative hit", event_count, 1);
        chk("R2 most negative no trip", trip_pulse, 0);

        // saturation both ways
        cfg_signed = 0; thr_value = 16'd10; cnt_limit = 8'd200;
        for (int i = 0; i < 300; i++) step(1, 16'd50);
        step(0, 0);
        chk("R3 saturate high", event_count, 255);
        for (int i = 0; i < 300; i++) step(1, 16'd1);
        step(0, 0);
        chk("R4 saturate low", event_count, 0);

        // off mode
        for (int i = 0; i < 5; i++) step(1, 16'd900);
        cfg_mode = 2'b00; step(1, 16'd900); step(0, 0);
        chk("R8 off count", event_count, 0);
        chk("R8 off trip", trip_pulse, 0);
        step(0, 0);
        finish_run();
    end
endmodule